// File: doc/BRIEF.md
# Vector Multiply-Sum Logical Unit

This unit takes three 128-bit source vectors. Each vector holds two unsigned 64-bit lanes. Lane 0 is the upper half of a vector, bits [127:64], and lane 1 is the lower half, bits [63:0]. The unit multiplies lane 0 of source A by lane 0 of source B, and lane 1 of source A by lane 1 of source B. Each of these is a full 64x64 unsigned multiply that gives a 128-bit product. Either product can be doubled on its own, as set by the mode field. Both products and source C, read as a single 128-bit number, are then summed modulo 2^128. The sum is returned with its upper 64 bits in lane 0 and its lower 64 bits in lane 1.

Requests arrive on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Only one request is in flight at a time: `req_ready` stays low from acceptance until the response has been handed over. The response channel is also valid/ready. Once `rsp_valid` rises, the result and the error flag stay frozen until the edge at which `rsp_ready` is high. The consumer may hold `rsp_ready` low for as long as it needs.

The two products are formed by iterative multipliers that process one digit of the multiplier operand per cycle. The latency is therefore ELEM_W/DIGIT_W + 1 cycles from acceptance to `rsp_valid`. A request with an unsupported element size skips the arithmetic and answers on the next cycle.

Top module: `vec_mulsum_unit`

## Requirements
- R1: Only element-size code 3 (4-bit field `req_esize`, meaning 64-bit lanes) is computed. Any other code gives a response with `rsp_spec_err`=1 and `rsp_result` all zero, one cycle after acceptance.
- R2: The lane-0 product is the unsigned 128-bit product of A[127:64] and B[127:64]. The lane-1 product is the unsigned 128-bit product of A[63:0] and B[63:0].
- R3: When mode bit 3 (value 8) is set, the lane-0 product is doubled before the sum.
- R4: When mode bit 2 (value 4) is set, the lane-1 product is doubled before the sum.
- R5: The result is the sum of both (possibly doubled) products and C[127:0], taken modulo 2^128. Every carry out of bit 127 is dropped, and no overflow indication is produced.
- R6: The upper 64 bits of the sum appear in `rsp_result[127:64]` (lane 0), and the lower 64 bits appear in `rsp_result[63:0]` (lane 1). A valid computed response has `rsp_spec_err`=0.
- R7: Mode bits 1 and 0 have no effect on the result.
- R8: `req_ready` is low from the cycle after acceptance until the cycle after the response handshake, at which point it returns high.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_result` and `rsp_spec_err` stay unchanged.
- R10: After reset, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_src_a | input | 128 | Multiplicand vector, two 64-bit lanes |
| req_src_b | input | 128 | Multiplier vector, two 64-bit lanes |
| req_src_c | input | 128 | 128-bit addend |
| req_esize | input | 4 | Element-size code; only 3 is supported |
| req_mode | input | 4 | Bit 3 doubles the lane-0 product, bit 2 doubles the lane-1 product, bits 1:0 are ignored |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_result | output | 128 | Sum, with lane 0 in the upper half |
| rsp_spec_err | output | 1 | Unsupported element size; result is zero |

## Verification
The checker watches the handshake rules on every cycle:
- the one-in-flight rule, with `req_ready` low after acceptance and high again after the response handshake;
- the frozen response under back-pressure;
- a zero result whenever the error flag is set;
- an error response on the cycle after any bad element size is accepted.

The arithmetic itself can only be shown by the bench's scenarios. These compare each result against a 256-bit reference sum. They sweep all sixteen mode values across zero, all-ones and pseudo-random operands. This covers every doubling combination, wrap-around beyond 128 bits, and the ignored low mode bits.

// File: rtl/mulsum_pkg.sv
package mulsum_pkg;
  localparam logic [3:0] ESIZE_DWORD = 4'd3;
  localparam int MODE_DBL_LANE0 = 3;
  localparam int MODE_DBL_LANE1 = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_RESP = 2'd2
  } mulsum_state_e;
endpackage

// File: rtl/mulsum_iter_mul.sv
// Unsigned W x W multiplier that retires one DIGIT_W-bit digit of b per cycle,
// most significant digit first (shift-and-add in radix 2^DIGIT_W).
module mulsum_iter_mul #(
  parameter int W       = 64,
  parameter int DIGIT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           busy,
  output logic [2*W-1:0] product
);
  localparam int STEPS = W / DIGIT_W;
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam int PW    = 2 * W;

  logic [W-1:0]       a_q, b_q;
  logic [PW-1:0]      acc_q, acc_next, partial;
  logic [CNT_W-1:0]   cnt_q;
  logic [DIGIT_W-1:0] digit;

  always_comb begin
    digit    = b_q[W-1 -: DIGIT_W];
    partial  = PW'(a_q) * PW'(digit);
    acc_next = (acc_q << DIGIT_W) + partial;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
      cnt_q <= '0;
    end else if (start) begin
      a_q   <= a;
      b_q   <= b;
      acc_q <= '0;
      cnt_q <= CNT_W'(STEPS);
    end else if (cnt_q != '0) begin
      acc_q <= acc_next;
      b_q   <= b_q << DIGIT_W;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy    = (cnt_q != '0);
  assign product = acc_q;
endmodule

// File: rtl/mulsum_accum.sv
// Optional doubling of each product, then a three-way sum modulo 2^W.
module mulsum_accum #(
  parameter int W             = 128,
  parameter bit DOUBLE_BY_ADD = 1'b1
) (
  input  logic [W-1:0] prod0,
  input  logic [W-1:0] prod1,
  input  logic [W-1:0] addend,
  input  logic         dbl0,
  input  logic         dbl1,
  output logic [W-1:0] sum
);
  logic [W-1:0] scaled0, scaled1;

  generate
    if (DOUBLE_BY_ADD) begin : g_dbl_add
      assign scaled0 = dbl0 ? (prod0 + prod0) : prod0;
      assign scaled1 = dbl1 ? (prod1 + prod1) : prod1;
    end else begin : g_dbl_shift
      assign scaled0 = dbl0 ? {prod0[W-2:0], 1'b0} : prod0;
      assign scaled1 = dbl1 ? {prod1[W-2:0], 1'b0} : prod1;
    end
  endgenerate

  assign sum = scaled0 + scaled1 + addend;
endmodule

// File: rtl/vec_mulsum_unit.sv
module vec_mulsum_unit #(
  parameter int ELEM_W        = 64,
  parameter int DIGIT_W       = 16,
  parameter bit DOUBLE_BY_ADD = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2*ELEM_W-1:0] req_src_a,
  input  logic [2*ELEM_W-1:0] req_src_b,
  input  logic [2*ELEM_W-1:0] req_src_c,
  input  logic [3:0]          req_esize,
  input  logic [3:0]          req_mode,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [2*ELEM_W-1:0] rsp_result,
  output logic                rsp_spec_err
);
  import mulsum_pkg::*;

  localparam int VEC_W = 2 * ELEM_W;
  localparam int LANES = 2;

  mulsum_state_e state_q;
  logic          accept, size_ok, mul_start;
  logic [VEC_W-1:0] addend_q, sum;
  logic          dbl0_q, dbl1_q;
  logic [VEC_W-1:0] result_q;
  logic          err_q;
  logic [LANES-1:0]  lane_busy;
  logic [VEC_W-1:0]  lane_prod [LANES];

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign size_ok   = (req_esize == ESIZE_DWORD);
  assign mul_start = accept && size_ok;

  // Lane l occupies bits [VEC_W-1-l*ELEM_W -: ELEM_W]: lane 0 is the upper half.
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      mulsum_iter_mul #(.W(ELEM_W), .DIGIT_W(DIGIT_W)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mul_start),
        .a       (req_src_a[VEC_W-1-l*ELEM_W -: ELEM_W]),
        .b       (req_src_b[VEC_W-1-l*ELEM_W -: ELEM_W]),
        .busy    (lane_busy[l]),
        .product (lane_prod[l])
      );
    end
  endgenerate

  mulsum_accum #(.W(VEC_W), .DOUBLE_BY_ADD(DOUBLE_BY_ADD)) u_accum (
    .prod0  (lane_prod[0]),
    .prod1  (lane_prod[1]),
    .addend (addend_q),
    .dbl0   (dbl0_q),
    .dbl1   (dbl1_q),
    .sum    (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addend_q <= '0;
      dbl0_q   <= 1'b0;
      dbl1_q   <= 1'b0;
      result_q <= '0;
      err_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addend_q <= req_src_c;
            dbl0_q   <= req_mode[MODE_DBL_LANE0];
            dbl1_q   <= req_mode[MODE_DBL_LANE1];
            if (size_ok) begin
              state_q <= ST_MUL;
            end else begin
              result_q <= '0;
              err_q    <= 1'b1;
              state_q  <= ST_RESP;
            end
          end
        end
        ST_MUL: begin
          if (lane_busy == '0) begin
            result_q <= sum;
            err_q    <= 1'b0;
            state_q  <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_result   = result_q;
  assign rsp_spec_err = err_q;
endmodule

// File: rtl/vec_mulsum_checker.sv
module vec_mulsum_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [3:0]       req_esize,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [VEC_W-1:0] rsp_result,
  input logic             rsp_spec_err
);
  assert_one_in_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_result) && $stable(rsp_spec_err)));

  assert_err_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_spec_err) |-> (rsp_result == '0));

  assert_bad_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_esize != 4'd3) |=> (rsp_valid && rsp_spec_err));
endmodule

bind vec_mulsum_unit vec_mulsum_checker #(.VEC_W(2*ELEM_W)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_esize    (req_esize),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_result   (rsp_result),
  .rsp_spec_err (rsp_spec_err)
);

// File: tb/tb_vec_mulsum_unit.sv
`timescale 1ns/1ps
module tb_vec_mulsum_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [127:0] req_src_a = '0, req_src_b = '0, req_src_c = '0;
  logic [3:0]   req_esize = 4'd3, req_mode = 4'd0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [127:0] rsp_result;
  logic         rsp_spec_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  vec_mulsum_unit dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src_a(req_src_a), .req_src_b(req_src_b), .req_src_c(req_src_c),
    .req_esize(req_esize), .req_mode(req_mode),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_result(rsp_result), .rsp_spec_err(rsp_spec_err)
  );

  function automatic logic [127:0] ref_sum(input logic [127:0] a, input logic [127:0] b,
                                           input logic [127:0] c, input logic [3:0] m);
    logic [255:0] p0, p1, s;
    p0 = {192'b0, a[127:64]} * {192'b0, b[127:64]};
    p1 = {192'b0, a[63:0]}   * {192'b0, b[63:0]};
    if (m[3]) p0 = p0 * 256'd2;
    if (m[2]) p1 = p1 * 256'd2;
    s = p0 + p1 + {128'b0, c};
    return s[127:0];
  endfunction

  function automatic logic [63:0] next_rng(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Drive one request; hold rsp_ready low for hold cycles once the response shows.
  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                        input logic [3:0] es, input logic [3:0] m, input int hold,
                        input string tag);
    logic [127:0] exp, held;
    bit exp_err;
    int waitc;
    exp_err = (es != 4'd3);
    exp = exp_err ? 128'd0 : ref_sum(a, b, c, m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_src_a = a; req_src_b = b; req_src_c = c;
    req_esize = es; req_mode = m;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8 busy after accept", {127'b0, req_ready}, 128'd0);
    if (exp_err)
      check(rsp_valid == 1'b1, "R1 error reply next cycle", {127'b0, rsp_valid}, 128'd1);
    waitc = 0;
    while (!rsp_valid && waitc < 100) begin @(negedge clk); waitc++; end
    check(rsp_valid == 1'b1, "R8 response arrives", {127'b0, rsp_valid}, 128'd1);
    held = rsp_result;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid && rsp_result == held, "R9 held under back-pressure", rsp_result, held);
    end
    check(rsp_spec_err == exp_err, {tag, " error flag"}, {127'b0, rsp_spec_err},
          {127'b0, exp_err});
    check(rsp_result == exp, tag, rsp_result, exp);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(req_ready && !rsp_valid, "R8 ready after handshake", {127'b0, req_ready}, 128'd1);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog expired actual=hang expected=completion");
    finish_run();
  end

  initial begin
    logic [127:0] a, b, c;
    string tag;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(req_ready == 1'b1, "R10 req_ready in reset", {127'b0, req_ready}, 128'd1);
    check(rsp_valid == 1'b0, "R10 rsp_valid in reset", {127'b0, rsp_valid}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R10 idle after reset", {127'b0, req_ready}, 128'd1);

    for (int s = 0; s < 8; s++) begin
      case (s)
        0: begin a = '0; b = '0; c = '0; end
        1: begin a = '1; b = '1; c = '1; end
        2: begin a = '1; b = '1; c = '0; end
        3: begin a = '0; b = '1; c = '1; end
        default: begin
          rng = next_rng(rng); a[127:64] = rng;
          rng = next_rng(rng); a[63:0]   = rng;
          rng = next_rng(rng); b[127:64] = rng;
          rng = next_rng(rng); b[63:0]   = rng;
          rng = next_rng(rng); c[127:64] = rng;
          rng = next_rng(rng); c[63:0]   = rng;
        end
      endcase
      for (int m = 0; m < 16; m++) begin
        if (m[1:0] != 2'b00)      tag = "R7 low mode bits ignored";
        else if (m[3] && m[2])    tag = "R3 R4 both doubled";
        else if (m[3])            tag = "R3 lane0 doubled";
        else if (m[2])            tag = "R4 lane1 doubled";
        else                      tag = "R2 R5 R6 plain sum";
        run_op(a, b, c, 4'd3, 4'(m), m % 3, tag);
      end
    end

    // Lane placement: only lane 1 operands, then only lane 0 operands (R6).
    run_op({64'd0, 64'd3}, {64'd0, 64'd5}, 128'd0, 4'd3, 4'd0, 0, "R6 low lane product");
    run_op({64'd7, 64'd0}, {64'd11, 64'd0}, 128'd0, 4'd3, 4'd0, 0, "R6 high lane product");
    // Wrap beyond 128 bits (R5).
    run_op('1, '1, '1, 4'd3, 4'hC, 2, "R5 wrap modulo 2^128");

    // Unsupported element sizes (R1).
    for (int e = 0; e < 16; e++) begin
      if (e != 3) run_op('1, '1, '1, 4'(e), 4'hF, e % 2, "R1 bad element size");
    end

    finish_run();
  end
endmodule